// File: doc/BRIEF.md
# JTAG Configuration Readback Sequencer

This block is a JTAG master that runs one fixed readback script against the configuration port of an attached device. It makes its own test clock from the system clock. It drives the mode-select and data-in lines bit by bit and samples the device's data-out line. On a start request it walks the device TAP through a set series of steps:

- an idle wait;
- loading of the configuration-input instruction;
- a preamble of eleven 32-bit command packets;
- loading of the configuration-output instruction;
- a readback of a programmable number of bits;
- a return to Test-Logic-Reset.

The readback bits are packed into 32-bit words and handed out with a one-cycle valid strobe. When the script is over, the block raises done.

A host pulses `start` with the readback length on `rdCount`. It then collects words from `rbData` whenever `rbValid` is high, and waits for `done`. The device-side TAP and the meaning of the readback data lie outside this block.

Top module: `jtag_readback_seq`

## Requirements
- R1: An asynchronous reset (rstN low) forces tms=1, tdi=0, tck=0, busy=0, done=0, rbValid=0 at once. While idle, tms stays 1 and tdi stays 0.
- R2: While busy, tck has a period of 2*HALF_DIV system clocks: low for the first half, high for the second half. It stays low while idle. tms and tdi only change while tck is low, and the device samples them on the rising edge of tck.
- R3: The first 12 tck bits carry tms=0. The next 4 carry tms=1,1,0,0, which enters Shift-IR.
- R4: An instruction is 10 bits shifted LSB first on tdi. tms is 0 on the first 9 bits and 1 on the 10th. The configuration-input instruction is the bit series 1,1,1,0,0,0,1,0,1,1.
- R5: After the first instruction, tms runs 1,1,0,0. Then 352 packet bits follow, MSB first of each word, in this word order: FFFFFFFF, AA995566, 20000000, 30008001, 00000004, 30002001, 00000000, 28006000, 48024090, 20000000, 20000000. tms is 0 on all but the last packet bit, where it is 1.
- R6: After the packets, tms runs 1,1,1,0,0. Next comes the configuration-output instruction, bit series 1,1,1,0,0,0,1,0,0,1, framed as in R4. Then tms runs 1,1,0,0.
- R7: The readback step shifts N bits, where N is rdCount latched when start is taken. A value of 0 counts as 1. tms is 0 on all but the last bit, where it is 1. tdo is sampled at each rising edge of tck.
- R8: Readback bits fill 32-bit words, with the first bit in bit 31. Each full word is shown on rbData with rbValid high for one cycle. A last partial word is left-justified and zero-filled, so ceil(N/32) words come out per run.
- R9: After the readback, tms runs 1,1,1,0,0 and then 1,1,1,1,1. done is then raised and busy dropped, after exactly 411+N tck bits in all.
- R10: start is taken only while idle, and taking it clears done. A start while busy changes neither the sequence nor N.
- R11: tdi is 0 on every bit that is not part of an instruction or a packet, including the readback bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, taken only when idle |
| rdCount | input | CNT_W | Readback bit count N, latched on start |
| tdo | input | 1 | Data from the device TAP |
| tck | output | 1 | Generated test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Data to the device TAP |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete, held until the next start |
| rbValid | output | 1 | One-cycle strobe for rbData |
| rbData | output | WORD_W | Packed readback word |

## Verification
The assertions take for granted that HALF_DIV is at least 2, so that tms and tdi settle a cycle after the falling edge and well before the next rising edge. They also take for granted that tdo changes only on the falling edge of tck, never in the system cycle where tck rises. The stimulus keeps within this: the bench's device model updates tdo just after each falling tck edge. It drives start and rdCount only between clock edges. The reset test drops rstN between clock edges in the middle of a run and releases it on a falling clock edge.

// File: rtl/jrb_pkg.sv
package jrb_pkg;

  localparam int IR_LEN    = 10;
  localparam int PKT_WORDS = 11;
  localparam int PKT_BITS  = PKT_WORDS * 32;

  typedef enum logic [4:0] {
    S_IDLE, S_RTI, S_SELIR_A, S_SHIR_A, S_IR_IN, S_SELDR_A, S_SHDR_A, S_PKT,
    S_SELIR_B, S_SHIR_B, S_IR_OUT, S_SELDR_B, S_SHDR_B, S_RDBK,
    S_SELIR_C, S_SHIR_C, S_TLR
  } stepE;

  typedef enum logic [1:0] { TDI_ZERO, TDI_INSTR, TDI_PKT } tdiSrcE;

  // per-bit strobes from control to datapath
  typedef struct packed {
    logic       tmsVal;
    tdiSrcE     tdiSrc;
    logic       instrOut;
    logic [8:0] bitIdx;
    logic       capture;
    logic       capLast;
  } bitCtlS;

endpackage

// File: rtl/jrb_ctrl.sv
module jrb_ctrl
  import jrb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] rdCount,
  input  logic             periodEnd,
  output logic             busy,
  output logic             done,
  output bitCtlS           ctl
);

  stepE             stepQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] rbLenQ;
  logic [CNT_W-1:0] curLen;
  logic             lastBit;

  assign busy = (stepQ != S_IDLE);

  always_comb begin
    case (stepQ)
      S_RTI:                   curLen = CNT_W'(12);
      S_SELIR_B, S_SELIR_C:    curLen = CNT_W'(3);
      S_IR_IN, S_IR_OUT:       curLen = CNT_W'(IR_LEN);
      S_PKT:                   curLen = CNT_W'(PKT_BITS);
      S_RDBK:                  curLen = rbLenQ;
      S_TLR:                   curLen = CNT_W'(5);
      S_IDLE:                  curLen = CNT_W'(1);
      default:                 curLen = CNT_W'(2);
    endcase
    lastBit = (cntQ == curLen - 1'b1);
  end

  always_comb begin
    ctl          = '0;
    ctl.bitIdx   = 9'(cntQ);
    ctl.instrOut = (stepQ == S_IR_OUT);
    ctl.capture  = (stepQ == S_RDBK);
    ctl.capLast  = (stepQ == S_RDBK) && lastBit;
    case (stepQ)
      S_IR_IN, S_IR_OUT: begin ctl.tmsVal = lastBit; ctl.tdiSrc = TDI_INSTR; end
      S_PKT:             begin ctl.tmsVal = lastBit; ctl.tdiSrc = TDI_PKT;   end
      S_RDBK:            ctl.tmsVal = lastBit;
      S_SELIR_A, S_SELDR_A, S_SELIR_B, S_SELDR_B, S_SELIR_C, S_TLR:
                         ctl.tmsVal = 1'b1;
      default:           ctl.tmsVal = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepQ  <= S_IDLE;
      cntQ   <= '0;
      rbLenQ <= CNT_W'(1);
      done   <= 1'b0;
    end else if (stepQ == S_IDLE) begin
      if (start) begin
        stepQ  <= S_RTI;
        cntQ   <= '0;
        rbLenQ <= (rdCount == '0) ? CNT_W'(1) : rdCount;
        done   <= 1'b0;
      end
    end else if (periodEnd) begin
      if (lastBit) begin
        cntQ <= '0;
        if (stepQ == S_TLR) begin
          stepQ <= S_IDLE;
          done  <= 1'b1;
        end else begin
          stepQ <= stepE'(stepQ + 5'd1);
        end
      end else begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  // R9: done and busy never overlap
  p_done_excl_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R10: a start while busy never restarts the script
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (stepQ != S_RTI || $past(stepQ) == S_RTI));

  // R7: readback length held for the whole run
  p_len_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(rbLenQ));

endmodule

// File: rtl/jrb_datapath.sv
module jrb_datapath
  import jrb_pkg::*;
#(
  parameter int              HALF_DIV = 2,
  parameter int              WORD_W   = 32,
  parameter logic [IR_LEN-1:0] IR_IN  = 10'h347,
  parameter logic [IR_LEN-1:0] IR_OUT = 10'h247
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  bitCtlS            ctl,
  input  logic              tdo,
  output logic              periodEnd,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  output logic              rbValid,
  output logic [WORD_W-1:0] rbData
);

  localparam int PH_W   = $clog2(2 * HALF_DIV);
  localparam int FILL_W = $clog2(WORD_W + 1);

  if (HALF_DIV < 2) begin : g_bad_div
    $error("HALF_DIV must be at least 2");
  end

  logic [PH_W-1:0]   phaseQ;
  logic              riseNow;
  logic              tdiBit;
  logic [IR_LEN-1:0] instrSh;
  logic [31:0]       pktW;
  logic [WORD_W-1:0] accQ, wordNext;
  logic [FILL_W-1:0] fillQ, fillNext;

  function automatic logic [31:0] pktWord(input logic [3:0] i);
    case (i)
      4'd0:    return 32'hFFFF_FFFF;
      4'd1:    return 32'hAA99_5566;
      4'd3:    return 32'h3000_8001;
      4'd4:    return 32'h0000_0004;
      4'd5:    return 32'h3000_2001;
      4'd6:    return 32'h0000_0000;
      4'd7:    return 32'h2800_6000;
      4'd8:    return 32'h4802_4090;
      default: return 32'h2000_0000;
    endcase
  endfunction

  assign periodEnd = busy && (phaseQ == PH_W'(2 * HALF_DIV - 1));
  assign riseNow   = busy && (phaseQ == PH_W'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= '0;
      tck    <= 1'b0;
    end else begin
      if (!busy || periodEnd) phaseQ <= '0;
      else                    phaseQ <= phaseQ + 1'b1;
      if (riseNow)                 tck <= 1'b1;
      else if (periodEnd || !busy) tck <= 1'b0;
    end
  end

  always_comb begin
    instrSh = (ctl.instrOut ? IR_OUT : IR_IN) >> ctl.bitIdx[3:0];
    pktW    = pktWord(ctl.bitIdx[8:5]);
    case (ctl.tdiSrc)
      TDI_INSTR: tdiBit = instrSh[0];
      TDI_PKT:   tdiBit = pktW[~ctl.bitIdx[4:0]];
      default:   tdiBit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tms <= 1'b1;
      tdi <= 1'b0;
    end else begin
      tms <= busy ? ctl.tmsVal : 1'b1;
      tdi <= busy ? tdiBit : 1'b0;
    end
  end

  assign wordNext = {accQ[WORD_W-2:0], tdo};
  assign fillNext = fillQ + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ    <= '0;
      fillQ   <= '0;
      rbValid <= 1'b0;
      rbData  <= '0;
    end else begin
      rbValid <= 1'b0;
      if (riseNow && ctl.capture) begin
        if (fillNext == FILL_W'(WORD_W) || ctl.capLast) begin
          rbData  <= wordNext << (FILL_W'(WORD_W) - fillNext);
          rbValid <= 1'b1;
          accQ    <= '0;
          fillQ   <= '0;
        end else begin
          accQ  <= wordNext;
          fillQ <= fillNext;
        end
      end
    end
  end

  // R2: test clock parked low when idle
  p_tck_idle_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !tck);

  // R2: tms/tdi settled before each rising edge
  p_setup_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tck) |-> ($stable(tms) && $stable(tdi)));

  // R1: idle lines held
  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> (tms && !tdi));

  // R8: valid is a single-cycle pulse
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    rbValid |=> !rbValid);

  // R8: words only come from readback captures
  p_valid_src_r8: assert property (@(posedge clk) disable iff (!rstN)
    rbValid |-> $past(ctl.capture));

endmodule

// File: rtl/jtag_readback_seq.sv
module jtag_readback_seq
  import jrb_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int CNT_W    = 16,
  parameter int WORD_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  rdCount,
  input  logic              tdo,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  output logic              busy,
  output logic              done,
  output logic              rbValid,
  output logic [WORD_W-1:0] rbData
);

  bitCtlS ctl;
  logic   periodEnd;

  jrb_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rdCount(rdCount),
    .periodEnd(periodEnd), .busy(busy), .done(done), .ctl(ctl)
  );

  jrb_datapath #(.HALF_DIV(HALF_DIV), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .busy(busy), .ctl(ctl), .tdo(tdo),
    .periodEnd(periodEnd), .tck(tck), .tms(tms), .tdi(tdi),
    .rbValid(rbValid), .rbData(rbData)
  );

endmodule

// File: tb/tb_jtag_readback_seq.sv
module tb_jtag_readback_seq;

  localparam int HALF  = 2;
  localparam int CW    = 16;
  localparam int WW    = 32;
  localparam int FIXED = 411;
  localparam int RB0   = 401;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] rdCount = '0;
  logic          tdo = 1'b0;
  logic          tck, tms, tdi, busy, done, rbValid;
  logic [WW-1:0] rbData;

  int nChecks = 0, nErr = 0;
  int cyc = 0, lastRise = 0;
  int k = 0, wordIdx = 0, curN = 1, curSeed = 0;
  bit mon = 1'b0;

  jtag_readback_seq #(.HALF_DIV(HALF), .CNT_W(CW), .WORD_W(WW)) dut (
    .clk(clk), .rstN(rstN), .start(start), .rdCount(rdCount), .tdo(tdo),
    .tck(tck), .tms(tms), .tdi(tdi), .busy(busy), .done(done),
    .rbValid(rbValid), .rbData(rbData)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s act=%0h exp=%0h (bit %0d, N=%0d)", req, act, exp, k, curN);
    end
  endtask

  function automatic logic [31:0] pkt(input int i);
    logic [31:0] w[11] = '{32'hFFFFFFFF, 32'hAA995566, 32'h20000000, 32'h30008001,
                          32'h00000004, 32'h30002001, 32'h00000000, 32'h28006000,
                          32'h48024090, 32'h20000000, 32'h20000000};
    return w[i];
  endfunction

  function automatic logic pat(input int i, input int seed);
    return (((i * 5 + seed) % 7) < 3);
  endfunction

  // expected tms/tdi for tck bit index b; seg tells which step it falls in
  task automatic expBit(input int b, input int n, output logic t, output logic d, output int seg);
    int len[16] = '{12, 2, 2, 10, 2, 2, 352, 3, 2, 10, 2, 2, 0, 3, 2, 5};
    logic fixT[16] = '{0, 1, 0, 0, 1, 0, 0, 1, 0, 0, 1, 0, 0, 1, 0, 1};
    logic [9:0] irIn = 10'b1101000111;   // series 1,1,1,0,0,0,1,0,1,1 LSB first
    logic [9:0] irOut = 10'b1001000111;  // series 1,1,1,0,0,0,1,0,0,1
    int base = 0, off;
    len[12] = n;
    t = 1'b1; d = 1'b0; seg = 16;
    for (int s = 0; s < 16; s++) begin
      if (seg == 16 && b < base + len[s]) begin
        seg = s; off = b - base;
        t = fixT[s]; d = 1'b0;
        if (s == 3 || s == 6 || s == 9 || s == 12) t = (off == len[s] - 1);
        if (s == 3) d = irIn[off];
        if (s == 9) d = irOut[off];
        if (s == 6) d = pkt(off / 32) >> (31 - off % 32);
      end
      base += len[s];
    end
  endtask

  function automatic string tmsTag(input int seg);
    if (seg <= 2) return "R3 tms";
    if (seg == 3) return "R4 tms";
    if (seg <= 6) return "R5 tms";
    if (seg <= 11) return "R6 tms";
    if (seg == 12) return "R7 tms";
    return "R9 tms";
  endfunction

  function automatic string tdiTag(input int seg);
    if (seg == 3) return "R4 tdi";
    if (seg == 6) return "R5 tdi";
    if (seg == 9) return "R6 tdi";
    return "R11 tdi";
  endfunction

  function automatic logic [31:0] expWord(input int w, input int n, input int seed);
    logic [31:0] r = '0;
    for (int j = 0; j < 32; j++)
      if (32 * w + j < n) r[31 - j] = pat(32 * w + j, seed);
    return r;
  endfunction

  // device-side view: sample tms/tdi on the rising edge of tck
  always @(posedge tck) begin
    #1;
    if (mon) begin
      logic et, ed;
      int seg;
      expBit(k, curN, et, ed, seg);
      chk(tms === et, tmsTag(seg), 32'(tms), 32'(et));
      chk(tdi === ed, tdiTag(seg), 32'(tdi), 32'(ed));
      if (k > 0) chk(cyc - lastRise == 2 * HALF, "R2 period", 32'(cyc - lastRise), 32'(2 * HALF));
      lastRise = cyc;
      k++;
    end
  end

  // device model: tdo changes right after the falling edge
  always @(negedge tck) begin
    #1;
    if (mon && k >= RB0 && k < RB0 + curN) tdo = pat(k - RB0, curSeed);
    else tdo = 1'b0;
  end

  always @(negedge clk) begin
    if (mon && rbValid) begin
      logic [31:0] e;
      e = expWord(wordIdx, curN, curSeed);
      chk(rbData === e, "R8 word", rbData, e);
      wordIdx++;
    end
  end

  task automatic launch(input int n, input int seed);
    curN = (n == 0) ? 1 : n; curSeed = seed;
    k = 0; wordIdx = 0; mon = 1'b1;
    @(negedge clk); start = 1'b1; rdCount = CW'(n);
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1 && done === 1'b0, "R10 start taken, done cleared", {busy, done}, 32'h2);
  endtask

  task automatic runSeq(input int n, input int seed, input bit poke);
    launch(n, seed);
    if (poke) begin
      repeat (300) @(negedge clk);
      start = 1'b1; rdCount = CW'(n + 7);
      @(negedge clk); start = 1'b0;
      chk(busy === 1'b1, "R10 start while busy", 32'(busy), 32'h1);
    end
    while (!done) @(negedge clk);
    mon = 1'b0;
    chk(k == FIXED + curN, "R9 bit total", 32'(k), 32'(FIXED + curN));
    chk(wordIdx == (curN + 31) / 32, "R8 word count", 32'(wordIdx), 32'((curN + 31) / 32));
    chk(busy === 1'b0 && tms === 1'b1 && tck === 1'b0, "R9 end state",
        {busy, tms, tck}, 32'h2);
    repeat (3) @(negedge clk);
    chk(tms === 1'b1 && tdi === 1'b0 && done === 1'b1, "R1 idle lines", {tms, tdi, done}, 32'h5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({tms, tdi, tck, busy, done, rbValid} === 6'b100000, "R1 reset state",
        32'({tms, tdi, tck, busy, done, rbValid}), 32'h20);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int n = 0; n <= 34; n++) runSeq(n, n + 1, 1'b0);
    runSeq(63, 2, 1'b0);
    runSeq(64, 3, 1'b0);
    runSeq(65, 4, 1'b1);
    runSeq(96, 5, 1'b0);
    runSeq(97, 6, 1'b1);

    // R1: asynchronous reset in the middle of a run
    launch(40, 9);
    repeat (600) @(negedge clk);
    mon = 1'b0;
    #3 rstN = 1'b0;
    #1;
    chk({tms, tdi, tck, busy, done, rbValid} === 6'b100000, "R1 async reset",
        32'({tms, tdi, tck, busy, done, rbValid}), 32'h20);
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy === 1'b0 && tms === 1'b1, "R1 idle after reset", {busy, tms}, 32'h1);
    runSeq(40, 9, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nErr++;
    $display("FAIL R9 watchdog: done never seen act=0 exp=1");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule